// File: doc/BRIEF.md
# Instruction Control and ALU-Control Decoder

This block is the control decoder for a 32-bit processor with three instruction formats. It takes one instruction word and produces, in the same cycle and with no storage, the steering and enable signals the datapath needs:
- destination-register select
- register-file write enable
- second-operand select
- data-memory read and write enables
- write-back source select
- a branch flag
- a 4-bit ALU operation code

It also combines the branch flag with the ALU zero flag to produce the next-PC select.

Decoding happens in two levels. A main decoder looks only at the opcode in bits [31:26]. It produces the control flags and a 2-bit operation class. A second decoder turns the class into the ALU code, and it reads the function field in bits [5:0] only when the class marks a register-register instruction.

The supported instructions are:
- register-register arithmetic and logic
- word load
- word store
- branch-if-equal

Every other opcode is decoded as a harmless no-operation.

Top module: `instr_decode`

## Requirements
- R1: Opcode 000000 (register-register) gives dst_sel_rd=1, reg_we=1, opb_sel_imm=0, mem_re=0, mem_we=0, wb_sel_mem=0, is_branch=0 and op_class=10.
- R2: Opcode 100011 (load) gives dst_sel_rd=0, reg_we=1, opb_sel_imm=1, mem_re=1, mem_we=0, wb_sel_mem=1, is_branch=0 and op_class=00.
- R3: Opcode 101011 (store) gives dst_sel_rd=0, reg_we=0, opb_sel_imm=1, mem_re=0, mem_we=1, wb_sel_mem=0, is_branch=0 and op_class=00.
- R4: Opcode 000100 (branch-if-equal) gives dst_sel_rd=0, reg_we=0, opb_sel_imm=0, mem_re=0, mem_we=0, wb_sel_mem=0, is_branch=1 and op_class=01.
- R5: When op_class is 00, alu_ctl is 0010 (add). When op_class is 01, alu_ctl is 0110 (subtract). In both cases the function field has no effect.
- R6: When op_class is 10, the function field in bits [5:0] selects alu_ctl. The mapping is 100000 to 0010, 100010 to 0110, 100100 to 0000, 100101 to 0001, 100111 to 1100 and 101010 to 0111.
- R7: When op_class is 10 and the function field holds any other value, alu_ctl is 0010.
- R8: Any other opcode drives every control output to 0 and op_class to 00, and gives alu_ctl 0010. With alu_zero=1, pc_next_sel stays 0.
- R9: pc_next_sel equals is_branch AND alu_zero.
- R10: mem_re and mem_we are never 1 at the same time.
- R11: Instruction bits [25:6] have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word |
| alu_zero | input | 1 | ALU result-is-zero flag |
| dst_sel_rd | output | 1 | 1: write register from bits [15:11]; 0: from bits [20:16] |
| reg_we | output | 1 | Register-file write enable |
| opb_sel_imm | output | 1 | 1: ALU operand B is the immediate; 0: a register |
| mem_re | output | 1 | Data-memory read enable |
| mem_we | output | 1 | Data-memory write enable |
| wb_sel_mem | output | 1 | 1: write back memory data; 0: write back ALU result |
| is_branch | output | 1 | Instruction is a conditional branch |
| op_class | output | 2 | Intermediate class: 00 memory, 01 branch, 10 register-register |
| alu_ctl | output | 4 | ALU operation code |
| pc_next_sel | output | 1 | 1: take branch target; 0: sequential PC |

## Verification
Every output is purely combinational, so each result is due in the same cycle as the instruction and zero flag that produce it. No register lies on any path.

The bench drives a new stimulus just after a rising clock edge. It samples all outputs at the following falling edge, half a period later, when the decode has long settled. Each check therefore sees exactly the stimulus of its own cycle and never a value left over from the previous one.

// File: rtl/instr_dec_pkg.sv
package instr_dec_pkg;

   localparam int OPC_W    = 6;
   localparam int FN_W     = 6;
   localparam int CLS_W    = 2;
   localparam int ALUCTL_W = 4;

   typedef enum logic [CLS_W-1:0] {
      CLS_MEM = 2'b00,
      CLS_BR  = 2'b01,
      CLS_REG = 2'b10,
      CLS_RSV = 2'b11
   } op_class_e;

   localparam logic [OPC_W-1:0] OPC_REG   = 6'b000000;
   localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
   localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
   localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;

   localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
   localparam logic [FN_W-1:0] FN_SUB = 6'b100010;
   localparam logic [FN_W-1:0] FN_AND = 6'b100100;
   localparam logic [FN_W-1:0] FN_OR  = 6'b100101;
   localparam logic [FN_W-1:0] FN_NOR = 6'b100111;
   localparam logic [FN_W-1:0] FN_SLT = 6'b101010;

   localparam logic [ALUCTL_W-1:0] ALU_AND = 4'b0000;
   localparam logic [ALUCTL_W-1:0] ALU_OR  = 4'b0001;
   localparam logic [ALUCTL_W-1:0] ALU_ADD = 4'b0010;
   localparam logic [ALUCTL_W-1:0] ALU_SUB = 4'b0110;
   localparam logic [ALUCTL_W-1:0] ALU_SLT = 4'b0111;
   localparam logic [ALUCTL_W-1:0] ALU_NOR = 4'b1100;

   typedef struct packed {
      logic dst_sel_rd;
      logic reg_we;
      logic opb_sel_imm;
      logic mem_re;
      logic mem_we;
      logic wb_sel_mem;
      logic is_branch;
   } ctrl_flags_t;

endpackage

// File: rtl/dec_main.sv
module dec_main
   import instr_dec_pkg::*;
(
   input  logic [OPC_W-1:0] opcode,
   output ctrl_flags_t      flags,
   output op_class_e        op_class
);

   always_comb begin
      flags    = '0;
      op_class = CLS_MEM;
      unique case (opcode)
         OPC_REG: begin
            flags.dst_sel_rd = 1'b1;
            flags.reg_we     = 1'b1;
            op_class         = CLS_REG;
         end
         OPC_LOAD: begin
            flags.reg_we      = 1'b1;
            flags.opb_sel_imm = 1'b1;
            flags.mem_re      = 1'b1;
            flags.wb_sel_mem  = 1'b1;
         end
         OPC_STORE: begin
            flags.opb_sel_imm = 1'b1;
            flags.mem_we      = 1'b1;
         end
         OPC_BEQ: begin
            flags.is_branch = 1'b1;
            op_class        = CLS_BR;
         end
         default: ;
      endcase
   end

   // Memory port handshake guards
   always_comb begin
      p_mem_excl_r10: assert (!(flags.mem_re && flags.mem_we))
         else $error("mem read and write both asserted");
      p_load_wb_r2: assert (!flags.wb_sel_mem || flags.mem_re)
         else $error("memory write-back without a memory read");
      p_branch_nowr_r4: assert (!flags.is_branch || (!flags.reg_we && !flags.mem_we))
         else $error("branch with a write enable");
   end

endmodule

// File: rtl/dec_alu.sv
module dec_alu
   import instr_dec_pkg::*;
(
   input  op_class_e            op_class,
   input  logic [FN_W-1:0]      funct,
   output logic [ALUCTL_W-1:0]  alu_ctl
);

   logic [ALUCTL_W-1:0] fn_ctl;

   always_comb begin
      unique case (funct)
         FN_ADD:  fn_ctl = ALU_ADD;
         FN_SUB:  fn_ctl = ALU_SUB;
         FN_AND:  fn_ctl = ALU_AND;
         FN_OR:   fn_ctl = ALU_OR;
         FN_NOR:  fn_ctl = ALU_NOR;
         FN_SLT:  fn_ctl = ALU_SLT;
         default: fn_ctl = ALU_ADD;
      endcase
   end

   always_comb begin
      unique case (op_class)
         CLS_REG: alu_ctl = fn_ctl;
         CLS_BR:  alu_ctl = ALU_SUB;
         default: alu_ctl = ALU_ADD;
      endcase
   end

   always_comb begin
      p_nonreg_fixed_r5: assert (op_class == CLS_REG ||
                                 alu_ctl == ALU_ADD || alu_ctl == ALU_SUB)
         else $error("non register class produced a function-derived code");
   end

endmodule

// File: rtl/pc_sel_gate.sv
module pc_sel_gate (
   input  logic is_branch,
   input  logic alu_zero,
   output logic pc_next_sel
);

   assign pc_next_sel = is_branch & alu_zero;

endmodule

// File: rtl/instr_decode.sv
module instr_decode
   import instr_dec_pkg::*;
#(
   parameter int INSTR_W = 32,
   parameter int OPC_LSB = 26
) (
   input  logic [INSTR_W-1:0]  instr,
   input  logic                alu_zero,
   output logic                dst_sel_rd,
   output logic                reg_we,
   output logic                opb_sel_imm,
   output logic                mem_re,
   output logic                mem_we,
   output logic                wb_sel_mem,
   output logic                is_branch,
   output logic [CLS_W-1:0]    op_class,
   output logic [ALUCTL_W-1:0] alu_ctl,
   output logic                pc_next_sel
);

   localparam int OPC_MSB = OPC_LSB + OPC_W - 1;

   generate
      if (OPC_MSB != INSTR_W - 1) begin : g_bad_opc_pos
         initial $fatal(1, "opcode must occupy the top bits of the word");
      end
      if (OPC_LSB <= FN_W) begin : g_bad_fn_overlap
         initial $fatal(1, "function field overlaps the opcode");
      end
   endgenerate

   ctrl_flags_t flags;
   op_class_e   cls;
   logic        unused_mid;

   assign unused_mid = ^instr[OPC_LSB-1:FN_W];

   dec_main u_main (
      .opcode   (instr[OPC_MSB:OPC_LSB]),
      .flags    (flags),
      .op_class (cls)
   );

   dec_alu u_alu (
      .op_class (cls),
      .funct    (instr[FN_W-1:0]),
      .alu_ctl  (alu_ctl)
   );

   pc_sel_gate u_pcsel (
      .is_branch   (flags.is_branch),
      .alu_zero    (alu_zero),
      .pc_next_sel (pc_next_sel)
   );

   assign dst_sel_rd  = flags.dst_sel_rd;
   assign reg_we      = flags.reg_we;
   assign opb_sel_imm = flags.opb_sel_imm;
   assign mem_re      = flags.mem_re;
   assign mem_we      = flags.mem_we;
   assign wb_sel_mem  = flags.wb_sel_mem;
   assign is_branch   = flags.is_branch;
   assign op_class    = cls;

   always_comb begin
      p_pcsel_needs_br_r9: assert (!pc_next_sel || (flags.is_branch && alu_zero))
         else $error("next-PC select without a taken branch");
      p_brclass_sub_r4: assert (cls != CLS_BR || alu_ctl == ALU_SUB)
         else $error("branch class did not select subtract");
   end

endmodule

// File: tb/tb_instr_decode.sv
module tb_instr_decode;

   logic        clk = 1'b0;
   logic [31:0] instr;
   logic        alu_zero;
   logic        dst_sel_rd, reg_we, opb_sel_imm, mem_re, mem_we, wb_sel_mem, is_branch;
   logic [1:0]  op_class;
   logic [3:0]  alu_ctl;
   logic        pc_next_sel;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   instr_decode dut (
      .instr(instr), .alu_zero(alu_zero),
      .dst_sel_rd(dst_sel_rd), .reg_we(reg_we), .opb_sel_imm(opb_sel_imm),
      .mem_re(mem_re), .mem_we(mem_we), .wb_sel_mem(wb_sel_mem),
      .is_branch(is_branch), .op_class(op_class), .alu_ctl(alu_ctl),
      .pc_next_sel(pc_next_sel)
   );

   // flags order: dst_sel_rd reg_we opb_sel_imm mem_re mem_we wb_sel_mem is_branch
   task automatic apply_chk(input string tag, input logic [31:0] w, input logic z,
                            input logic [6:0] ef, input logic [1:0] ec,
                            input logic [3:0] ea, input logic ep);
      logic [6:0] af;
      @(posedge clk);
      instr    <= w;
      alu_zero <= z;
      @(negedge clk);
      af = {dst_sel_rd, reg_we, opb_sel_imm, mem_re, mem_we, wb_sel_mem, is_branch};
      checks++;
      if (af !== ef || op_class !== ec || alu_ctl !== ea || pc_next_sel !== ep) begin
         errors++;
         $display("FAIL %s instr=%h: flags=%b cls=%b alu=%b pc=%b expected flags=%b cls=%b alu=%b pc=%b",
                  tag, w, af, op_class, alu_ctl, pc_next_sel, ef, ec, ea, ep);
      end
      checks++;
      if (mem_re && mem_we) begin
         errors++;
         $display("FAIL R10 instr=%h: mem_re=%b mem_we=%b expected not both 1",
                  w, mem_re, mem_we);
      end
   endtask

   function automatic logic [31:0] mk(input logic [5:0] opc, input logic [19:0] mid,
                                      input logic [5:0] fn);
      return {opc, mid, fn};
   endfunction

   task automatic t_reset_state;
      // all-zero word: register class, unknown funct -> add (R1, R7)
      apply_chk("R1/R7 zero word", 32'h0, 1'b0, 7'b1100000, 2'b10, 4'b0010, 1'b0);
   endtask

   task automatic t_reg_funcs;
      logic [5:0] fns [6] = '{6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b100111, 6'b101010};
      logic [3:0] exp [6] = '{4'b0010, 4'b0110, 4'b0000, 4'b0001, 4'b1100, 4'b0111};
      for (int i = 0; i < 6; i++) begin
         apply_chk("R1/R6", mk(6'b000000, 20'h0, fns[i]), 1'b1, 7'b1100000, 2'b10, exp[i], 1'b0);
         apply_chk("R6/R11 mid bits", mk(6'b000000, 20'hFFFFF ^ (20'h1357 * (i + 1)), fns[i]),
                   1'b0, 7'b1100000, 2'b10, exp[i], 1'b0);
      end
      apply_chk("R7 funct 111111", mk(6'b000000, 20'h0, 6'b111111), 1'b0, 7'b1100000, 2'b10, 4'b0010, 1'b0);
      apply_chk("R7 funct 100001", mk(6'b000000, 20'h0, 6'b100001), 1'b0, 7'b1100000, 2'b10, 4'b0010, 1'b0);
   endtask

   task automatic t_load;
      apply_chk("R2 load", mk(6'b100011, 20'h12345, 6'b000000), 1'b0, 7'b0111010, 2'b00, 4'b0010, 1'b0);
      apply_chk("R5 load funct ignored", mk(6'b100011, 20'h0, 6'b100100), 1'b1, 7'b0111010, 2'b00, 4'b0010, 1'b0);
   endtask

   task automatic t_store;
      apply_chk("R3 store", mk(6'b101011, 20'hABCDE, 6'b101010), 1'b0, 7'b0010100, 2'b00, 4'b0010, 1'b0);
      apply_chk("R5 store funct ignored", mk(6'b101011, 20'h0, 6'b100111), 1'b1, 7'b0010100, 2'b00, 4'b0010, 1'b0);
   endtask

   task automatic t_branch;
      apply_chk("R4/R9 beq not taken", mk(6'b000100, 20'h0, 6'b000000), 1'b0, 7'b0000001, 2'b01, 4'b0110, 1'b0);
      apply_chk("R4/R9 beq taken", mk(6'b000100, 20'hFFFFF, 6'b000000), 1'b1, 7'b0000001, 2'b01, 4'b0110, 1'b1);
      apply_chk("R5 beq funct ignored", mk(6'b000100, 20'h0, 6'b100101), 1'b1, 7'b0000001, 2'b01, 4'b0110, 1'b1);
   endtask

   task automatic t_illegal;
      logic [5:0] opcs [4] = '{6'b000010, 6'b111111, 6'b001000, 6'b100000};
      for (int i = 0; i < 4; i++)
         apply_chk("R8/R9 illegal opcode", mk(opcs[i], 20'h5A5A5, 6'b100010), 1'b1,
                   7'b0000000, 2'b00, 4'b0010, 1'b0);
   endtask

   task automatic finish_run;
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      instr    = '0;
      alu_zero = 1'b0;
      t_reset_state();
      t_reg_funcs();
      t_load();
      t_store();
      t_branch();
      t_illegal();
      finish_run();
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         finish_run();
      end
   end

endmodule